// File: doc/BRIEF.md
# Bennett Power-Clock Phase Sequencer

This block drives the power-clock rails of a chain of logic levels in an adiabatic datapath that uses Bennett-style timing. When a start request is accepted, the first level's positive rail ramps linearly from relaxed to half-supply. Once that ramp is complete and the rail is constant, the next level begins. After the last level reaches full value, a one-cycle result-valid pulse tells the consumer to capture the output. The levels then ramp back to relaxed one at a time, last level first. When the first level is relaxed again, an operand-release pulse says the inputs may change. Every level has a negative rail that mirrors its positive rail below zero.

Each rail is a 9-bit code. On the positive rail, code 0 is relaxed, 255 is half-supply and 510 is full supply. The negative rail is the two's complement negation of the positive code. Ramp length is a programmable number of system clocks, sampled when a sequence is accepted. A static mode bypasses sequencing: it ties every positive rail to full supply and every negative rail to ground, so the datapath runs as ordinary irreversible logic. Start, static mode and the pulses are plain control pins. No data stream passes through this block, so there is no back-pressure.

Top module: `bennett_phase_seq`

## Requirements
- R1: While reset is asserted, every positive and negative rail code is 0, and busy, result_valid and operand_release are 0.
- R2: Let L be the accepted ramp length and count edges from the accepting edge (edge 0). Level k (0-based) ramps up over edges kL+1 to (k+1)L. After ramp step i its positive code is floor(i*255/L). Levels above k read 0.
- R3: result_valid is high for exactly one cycle: the cycle after edge 11L, when the last level's positive code first reads 255.
- R4: The de-compute sweep ramps levels down in reverse order. Level k does so over edges 11L+(10-k)L+1 to 11L+(11-k)L. After down step i its positive code is floor((L-i)*255/L).
- R5: Whenever a level's positive code is nonzero, every lower-numbered level reads 255 (static mode excepted).
- R6: Outside static mode, each 9-bit negative rail code equals the two's complement negation of the same level's positive code.
- R7: operand_release pulses for one cycle after edge 22L, when level 0 is relaxed. busy is high from edge 0 up to that edge and low from it.
- R8: A start request is ignored while busy is high or static mode is set.
- R9: ramp_len is sampled only on the accepting edge. A value of 0 is taken as 1, and later changes to ramp_len do not affect the running sequence.
- R10: While static_mode is high, every positive rail reads 510 and every negative rail reads 0. On the next edge the sequence is aborted: busy goes low and the held codes are relaxed.
- R11: A start request held during the cycle in which operand_release is high is accepted on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| static_mode | input | 1 | Static irreversible bypass: full-swing rails, no sequencing |
| start_req | input | 1 | Request to run one compute/de-compute sequence |
| ramp_len | input | 8 | Ramp length in system clocks (0 treated as 1) |
| pos_rail | output | 99 | Positive rail codes, level k in bits [9k+8:9k] |
| neg_rail | output | 99 | Negative rail codes (two's complement), same layout |
| busy | output | 1 | Sequence running; operands must be held |
| result_valid | output | 1 | One-cycle pulse when the last level is at full value |
| operand_release | output | 1 | One-cycle pulse when level 0 has relaxed |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a start request and result_valid. The bench raises start_req during the cycle in which result_valid is high. It then requires the de-compute sweep to carry on exactly as the model predicts, with busy never dropping.

The second pair is operand_release and a new start request. The bench presents start during the release cycle. It expects busy to rise on the next edge and every rail to read relaxed.

In every run the ramp length presented to the block is changed right after acceptance. This shows that only the sampled length shapes the waveform.

// File: rtl/bennett_pkg.sv
package bennett_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_UP   = 2'd1,
    PH_DOWN = 2'd2
  } phase_t;
endpackage

// File: rtl/bennett_sweep_ctrl.sv
module bennett_sweep_ctrl
  import bennett_pkg::*;
#(
  parameter int N_LVL  = 11,
  parameter int CODE_W = 8,
  parameter int LEN_W  = 8,
  localparam int LVL_W = $clog2(N_LVL),
  localparam int FULL  = (1 << CODE_W) - 1,
  localparam int PROD_W = LEN_W + 1 + CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              static_mode,
  input  logic              start_req,
  input  logic [LEN_W-1:0]  ramp_len,
  output logic              wr_en,
  output logic [LVL_W-1:0]  wr_lvl,
  output logic [CODE_W-1:0] wr_code,
  output logic              busy,
  output logic              result_valid,
  output logic              operand_release
);
  phase_t             phase;
  logic [LVL_W-1:0]   lvl;
  logic [LEN_W-1:0]   cnt;
  logic [LEN_W-1:0]   len_q;
  logic [LEN_W:0]     cnt_n;
  logic [LEN_W:0]     num;
  logic [PROD_W-1:0]  prod;
  logic [PROD_W-1:0]  quo;
  logic               ramp_done;

  assign cnt_n     = {1'b0, cnt} + 1'b1;
  assign ramp_done = (cnt_n == {1'b0, len_q});
  assign num       = (phase == PH_UP) ? cnt_n : ({1'b0, len_q} - cnt_n);
  assign prod      = PROD_W'(num) * PROD_W'(FULL);
  assign quo       = prod / PROD_W'(len_q);
  assign wr_en     = (phase != PH_IDLE) && !static_mode;
  assign wr_lvl    = lvl;
  assign wr_code   = quo[CODE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase           <= PH_IDLE;
      lvl             <= '0;
      cnt             <= '0;
      len_q           <= LEN_W'(1);
      busy            <= 1'b0;
      result_valid    <= 1'b0;
      operand_release <= 1'b0;
    end else begin
      result_valid    <= 1'b0;
      operand_release <= 1'b0;
      if (static_mode) begin
        phase <= PH_IDLE;
        busy  <= 1'b0;
        cnt   <= '0;
        lvl   <= '0;
      end else begin
        case (phase)
          PH_IDLE: if (start_req) begin
            phase <= PH_UP;
            lvl   <= '0;
            cnt   <= '0;
            len_q <= (ramp_len == '0) ? LEN_W'(1) : ramp_len;
            busy  <= 1'b1;
          end
          PH_UP: begin
            if (ramp_done) begin
              cnt <= '0;
              if (lvl == LVL_W'(N_LVL - 1)) begin
                phase        <= PH_DOWN;
                result_valid <= 1'b1;
              end else begin
                lvl <= lvl + 1'b1;
              end
            end else begin
              cnt <= cnt_n[LEN_W-1:0];
            end
          end
          PH_DOWN: begin
            if (ramp_done) begin
              cnt <= '0;
              if (lvl == '0) begin
                phase           <= PH_IDLE;
                busy            <= 1'b0;
                operand_release <= 1'b1;
              end else begin
                lvl <= lvl - 1'b1;
              end
            end else begin
              cnt <= cnt_n[LEN_W-1:0];
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  // R8
  busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_req) && !$past(static_mode));

  // R10
  static_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    static_mode |=> !busy);

  // R3
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
endmodule

// File: rtl/bennett_rail_bank.sv
module bennett_rail_bank #(
  parameter int N_LVL  = 11,
  parameter int CODE_W = 8,
  localparam int LVL_W  = $clog2(N_LVL),
  localparam int RAIL_W = CODE_W + 1,
  localparam int FULL   = (1 << CODE_W) - 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    static_mode,
  input  logic                    wr_en,
  input  logic [LVL_W-1:0]        wr_lvl,
  input  logic [CODE_W-1:0]       wr_code,
  output logic [N_LVL*RAIL_W-1:0] pos_rail,
  output logic [N_LVL*RAIL_W-1:0] neg_rail,
  output logic                    last_full,
  output logic                    all_relaxed
);
  logic [CODE_W-1:0] code [N_LVL];
  logic [N_LVL-1:0]  nz;

  for (genvar k = 0; k < N_LVL; k++) begin : g_lvl
    logic [RAIL_W-1:0] ext;
    assign ext = {1'b0, code[k]};
    assign nz[k] = (code[k] != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   code[k] <= '0;
      else if (static_mode)                         code[k] <= '0;
      else if (wr_en && (wr_lvl == LVL_W'(k)))      code[k] <= wr_code;
    end

    assign pos_rail[k*RAIL_W +: RAIL_W] = static_mode ? RAIL_W'(2 * FULL) : ext;
    assign neg_rail[k*RAIL_W +: RAIL_W] = static_mode ? '0 : (RAIL_W'(0) - ext);

    if (k > 0) begin : g_hold
      // R5
      hold_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code[k] != '0) |-> (code[k-1] == CODE_W'(FULL)));
    end
  end

  assign last_full   = (code[N_LVL-1] == CODE_W'(FULL));
  assign all_relaxed = (nz == '0);
endmodule

// File: rtl/bennett_phase_seq.sv
module bennett_phase_seq #(
  parameter int N_LVL  = 11,
  parameter int CODE_W = 8,
  parameter int LEN_W  = 8,
  localparam int LVL_W  = $clog2(N_LVL),
  localparam int RAIL_W = CODE_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    static_mode,
  input  logic                    start_req,
  input  logic [LEN_W-1:0]        ramp_len,
  output logic [N_LVL*RAIL_W-1:0] pos_rail,
  output logic [N_LVL*RAIL_W-1:0] neg_rail,
  output logic                    busy,
  output logic                    result_valid,
  output logic                    operand_release
);
  logic              wr_en;
  logic [LVL_W-1:0]  wr_lvl;
  logic [CODE_W-1:0] wr_code;
  logic              last_full;
  logic              all_relaxed;

  bennett_sweep_ctrl #(.N_LVL(N_LVL), .CODE_W(CODE_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .static_mode(static_mode), .start_req(start_req),
    .ramp_len(ramp_len), .wr_en(wr_en), .wr_lvl(wr_lvl), .wr_code(wr_code),
    .busy(busy), .result_valid(result_valid), .operand_release(operand_release)
  );

  bennett_rail_bank #(.N_LVL(N_LVL), .CODE_W(CODE_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .static_mode(static_mode), .wr_en(wr_en),
    .wr_lvl(wr_lvl), .wr_code(wr_code), .pos_rail(pos_rail), .neg_rail(neg_rail),
    .last_full(last_full), .all_relaxed(all_relaxed)
  );

  // R3
  valid_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> last_full);

  // R7
  release_relaxed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    operand_release |-> all_relaxed && !busy);
endmodule

// File: tb/sim_bennett_phase_seq.sv
`timescale 1ns/1ps
module sim_bennett_phase_seq;
  localparam int N = 11;
  localparam int RW = 9;
  localparam int NT = 5;
  localparam int LENS [NT] = '{1, 2, 3, 5, 16};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic static_mode = 1'b0;
  logic start_req = 1'b0;
  logic [7:0] ramp_len = 8'd1;
  logic [N*RW-1:0] pos_rail, neg_rail;
  logic busy, result_valid, operand_release;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  bennett_phase_seq u0 (
    .clk(clk), .rst_n(rst_n), .static_mode(static_mode), .start_req(start_req),
    .ramp_len(ramp_len), .pos_rail(pos_rail), .neg_rail(neg_rail), .busy(busy),
    .result_valid(result_valid), .operand_release(operand_release)
  );

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int exp_code(int L, int t, int k);
    int u;
    if (t <= 11 * L) u = t - k * L;
    else u = L - (t - 11 * L - (10 - k) * L);
    if (u < 0) u = 0;
    if (u > L) u = L;
    return (u * 255) / L;
  endfunction

  function automatic logic [2*N*RW-1:0] exp_rails(int L, int t);
    logic [N*RW-1:0] p, n;
    for (int k = 0; k < N; k++) begin
      p[k*RW +: RW] = RW'(exp_code(L, t, k));
      n[k*RW +: RW] = RW'(0) - RW'(exp_code(L, t, k));
    end
    return {p, n};
  endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start_req = 1'b0; static_mode = 1'b0;
    tick();
    // R1 reset state
    chk("R1 rails in reset", 256'({pos_rail, neg_rail}), 256'(0));
    chk("R1 flags in reset", 256'({busy, result_valid, operand_release}), 256'(0));
    rst_n = 1'b1;
    tick();
  endtask

  task automatic run_check(input int len_in, input int L);
    ramp_len = 8'(len_in); start_req = 1'b1;
    tick();
    start_req = 1'b0;
    ramp_len = 8'(len_in + 7); // R9 change after acceptance
    for (int t = 0; t <= 22 * L; t++) begin
      if (t > 0) tick();
      // R2 R4 R5 R6 R9 rail waveform
      chk("R2 R4 R5 R6 R9 rails", 256'({pos_rail, neg_rail}), 256'(exp_rails(L, t)));
      // R3 R7 R8 flags
      chk("R3 R7 R8 flags", 256'({busy, result_valid, operand_release}),
          256'({t < 22 * L, t == 11 * L, t == 22 * L}));
      start_req = (t == 11 * L) || (t == 22 * L);
      if (t == 22 * L) ramp_len = 8'(len_in);
    end
    tick();
    start_req = 1'b0;
    // R11 restart from release cycle
    chk("R11 restart busy", 256'(busy), 256'(1));
    chk("R11 restart rails relaxed", 256'({pos_rail, neg_rail}), 256'(0));
    do_reset();
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [N*RW-1:0] full_p;
    for (int k = 0; k < N; k++) full_p[k*RW +: RW] = RW'(510);
    tick();
    do_reset();
    for (int i = 0; i < NT; i++) run_check(LENS[i], LENS[i]);
    // R9 zero length taken as one
    run_check(0, 1);

    // R10 static mode with a start request (R8 ignored)
    static_mode = 1'b1; start_req = 1'b1;
    tick();
    chk("R10 static pos rails", 256'(pos_rail), 256'(full_p));
    chk("R10 static neg rails", 256'(neg_rail), 256'(0));
    chk("R8 start ignored in static", 256'(busy), 256'(0));
    static_mode = 1'b0; start_req = 1'b0;
    tick();
    chk("R8 no sequence after static", 256'({busy, pos_rail, neg_rail}), 256'(0));

    // R10 abort mid-sequence
    ramp_len = 8'd4; start_req = 1'b1;
    tick();
    start_req = 1'b0;
    for (int i = 0; i < 14; i++) tick();
    chk("R2 mid-run level 3 ramping", 256'(pos_rail[3*RW +: RW]), 256'(127));
    static_mode = 1'b1;
    tick();
    chk("R10 abort busy low", 256'(busy), 256'(0));
    static_mode = 1'b0;
    tick();
    chk("R10 abort rails relaxed", 256'({pos_rail, neg_rail}), 256'(0));

    // R1 reset mid-sequence
    start_req = 1'b1;
    tick();
    start_req = 1'b0;
    for (int i = 0; i < 30; i++) tick();
    do_reset();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule